// File: doc/BRIEF.md
# Dual-Direction Latch/Register Bus Transceiver

This block connects two 18-bit ports, called A and B, with one data path in each direction. Each path has its own storage element. While its latch enable is high, the element is transparent and the output follows the input. While the latch enable is low, the element holds its value and updates only on a rising edge of its own data clock, and only when the active-low clock enable allows it. Each path also has an active-low output enable. High impedance is shown as a separate drive flag next to each data output, so the pad ring or the bus fabric above can build the actual tri-state buffer.

The data clocks are treated as ordinary control inputs. The block samples them with the system clock `clk`. A data clock that reads low on one `clk` edge and high on the next counts as a rising edge, and the capture happens on that second edge. The history register for each data clock keeps tracking through reset. Because of this, a rising edge that straddles the release of reset is still detected.

Top module: `ubt_xcvr`

## Requirements
- R1: Each direction carries W = 18 bits. `b_out` and `a_out` are 18 bits wide.
- R2: While a direction's latch enable (`ab_le` or `ba_le`) is 1, its data output equals its data input in the same cycle, without waiting for a clock edge. Data clock edges have no further effect while it is 1.
- R3: While the latch enable is 0 and no rising data clock edge is sampled, the data output keeps its value.
- R4: While the latch enable is 0 and the clock enable (`ab_clken_n` or `ba_clken_n`) is 0, a data clock sampled 0 and then 1 on consecutive `clk` edges stores the input present at the second edge. The output shows that value from that edge on.
- R5: A rising data clock edge while the clock enable is 1 leaves the stored value unchanged.
- R6: When the latch enable goes from 1 to 0, the output keeps the input value sampled at the last `clk` edge on which the latch enable was 1.
- R7: `b_drive` is 1 exactly when `ab_oe_n` is 0, and `a_drive` is 1 exactly when `ba_oe_n` is 0. A port whose drive flag is 0 is free for an outside source, so no contention occurs there.
- R8: The two directions are independent. Loading or clocking one direction never alters the value held by the other.
- R9: An active-low `rst_n` clears both stored values to 0 asynchronously. The drive flags keep following their output enables during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all controls |
| rst_n | input | 1 | Asynchronous active-low reset of storage |
| a_in | input | 18 | Data arriving on port A |
| b_in | input | 18 | Data arriving on port B |
| ab_le | input | 1 | A-to-B latch enable, 1 = transparent |
| ab_clk | input | 1 | A-to-B data clock, rising edge captures |
| ab_clken_n | input | 1 | A-to-B clock enable, active low |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ba_le | input | 1 | B-to-A latch enable, 1 = transparent |
| ba_clk | input | 1 | B-to-A data clock, rising edge captures |
| ba_clken_n | input | 1 | B-to-A clock enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| b_out | output | 18 | Data presented toward port B |
| b_drive | output | 1 | 1 = drive port B, 0 = high impedance |
| a_out | output | 18 | Data presented toward port A |
| a_drive | output | 1 | 1 = drive port A, 0 = high impedance |

## Verification
The hardest case to reach is a rising data clock edge while the latch enable is low. The edge exists only as two consecutive samples of a control input, so it has to be set up deliberately. A single disabled edge must be seen to change nothing, and the very next enabled edge must capture. The stimulus table walks one direction through transparent, fall-and-hold, enabled capture, disabled capture and a clock edge under a high latch enable, one `clk` cycle per row, so each expected value follows from the rows above it. Directed steps then clock each direction while the other holds a distinct value. A monitor flags any cycle in which the block drives a port that the bench itself is sourcing.

// File: rtl/ubt_xcvr.sv
module ubt_xcvr #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         ab_le,
  input  logic         ab_clk,
  input  logic         ab_clken_n,
  input  logic         ab_oe_n,
  input  logic         ba_le,
  input  logic         ba_clk,
  input  logic         ba_clken_n,
  input  logic         ba_oe_n,
  output logic [W-1:0] b_out,
  output logic         b_drive,
  output logic [W-1:0] a_out,
  output logic         a_drive
);

  logic [1:0][W-1:0] din, dout;
  logic [1:0]        le, ck, cen_n;

  assign din   = {b_in, a_in};
  assign le    = {ba_le, ab_le};
  assign ck    = {ba_clk, ab_clk};
  assign cen_n = {ba_clken_n, ab_clken_n};

  for (genvar d = 0; d < 2; d++) begin : g_dir
    logic [W-1:0] q;
    logic         ck_prev;
    logic         load;

    always_ff @(posedge clk) ck_prev <= ck[d];

    assign load = le[d] | (ck[d] & ~ck_prev & ~cen_n[d]);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)    q <= '0;
      else if (load) q <= din[d];

    assign dout[d] = le[d] ? din[d] : q;

    // R4: enabled rising edge under a low latch enable stores the input
    a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (!le[d] && ck[d] && !$past(ck[d]) && !cen_n[d])
      |=> (le[d] || dout[d] == $past(din[d])));

    // R5: a disabled edge changes nothing
    a_r5_clken_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (!le[d] && ck[d] && !$past(ck[d]) && cen_n[d])
      |=> (le[d] || $stable(dout[d])));

    // R3: without an edge the held value stays
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!le[d] && !(ck[d] && !$past(ck[d])))
      |=> (le[d] || $stable(dout[d])));

    // R6: the value present while transparent is kept after the fall
    a_r6_fall_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      le[d] |=> (le[d] || dout[d] == $past(din[d])));
  end

  assign b_out   = dout[0];
  assign a_out   = dout[1];
  assign b_drive = ~ab_oe_n;
  assign a_drive = ~ba_oe_n;

endmodule

// File: tb/ubt_xcvr_tb.sv
module ubt_xcvr_tb;
  localparam int W = 18;

  logic clk = 0;
  logic rst_n = 0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic ab_le = 0, ab_clk = 0, ab_clken_n = 0, ab_oe_n = 1;
  logic ba_le = 0, ba_clk = 0, ba_clken_n = 0, ba_oe_n = 1;
  logic [W-1:0] b_out, a_out;
  logic b_drive, a_drive;

  int checks = 0, fails = 0, contention = 0;
  logic tb_drv_a = 1, tb_drv_b = 1;
  logic done = 0;

  always #5 clk = ~clk;

  ubt_xcvr #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
    .ab_le(ab_le), .ab_clk(ab_clk), .ab_clken_n(ab_clken_n), .ab_oe_n(ab_oe_n),
    .ba_le(ba_le), .ba_clk(ba_clk), .ba_clken_n(ba_clken_n), .ba_oe_n(ba_oe_n),
    .b_out(b_out), .b_drive(b_drive), .a_out(a_out), .a_drive(a_drive)
  );

  // R7 contention monitor: the bench sources a port while its flag says so
  always @(negedge clk) begin
    if (tb_drv_b && b_drive) contention++;
    if (tb_drv_a && a_drive) contention++;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // {ab_le, ab_clk, ab_clken_n, a_in, expected b_out}
  localparam logic [38:0] VEC [12] = '{
    {1'b1, 1'b0, 1'b0, 18'h12345, 18'h12345},  // R2
    {1'b1, 1'b0, 1'b0, 18'h00ABC, 18'h00ABC},  // R2
    {1'b0, 1'b0, 1'b0, 18'h3FFFF, 18'h00ABC},  // R6
    {1'b0, 1'b1, 1'b0, 18'h15555, 18'h00ABC},  // R4 edge sampled here
    {1'b0, 1'b1, 1'b0, 18'h2AAAA, 18'h15555},  // R4, R3
    {1'b0, 1'b0, 1'b0, 18'h00001, 18'h15555},  // R3
    {1'b0, 1'b1, 1'b1, 18'h00F0F, 18'h15555},  // R5 disabled edge
    {1'b0, 1'b0, 1'b0, 18'h0F0F0, 18'h15555},  // R5
    {1'b0, 1'b1, 1'b0, 18'h0F0F0, 18'h15555},  // R4 edge
    {1'b0, 1'b1, 1'b0, 18'h00000, 18'h0F0F0},  // R4
    {1'b1, 1'b1, 1'b0, 18'h3C3C3, 18'h3C3C3},  // R2 clock ignored
    {1'b0, 1'b0, 1'b0, 18'h00000, 18'h3C3C3}   // R6
  };

  initial begin
    repeat (2) @(negedge clk);
    #1;
    check("R9 reset b_out", b_out, 0);
    check("R9 reset a_out", a_out, 0);
    check("R9 drive during reset", {a_drive, b_drive}, 0);
    check("R1 width", $bits(b_out), 18);
    @(negedge clk);
    rst_n = 1;

    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      {ab_le, ab_clk, ab_clken_n, a_in} = VEC[i][38:18];
      #1;
      check($sformatf("R2-6 vector %0d", i), b_out, VEC[i][17:0]);
    end

    // B-to-A mirror and independence (R8)
    @(negedge clk); ba_le = 1; b_in = 18'h2468A; #1;
    check("R2 ba transparent", a_out, 18'h2468A);
    @(negedge clk); ba_le = 0; b_in = 18'h11111; #1;
    check("R6 ba fall", a_out, 18'h2468A);
    @(negedge clk); ab_clk = 1; a_in = 18'h00077;
    @(negedge clk); #1;
    check("R4 ab capture", b_out, 18'h00077);
    check("R8 a_out untouched", a_out, 18'h2468A);
    @(negedge clk); ba_clk = 1; b_in = 18'h33333;
    @(negedge clk); b_in = 18'h00000; #1;
    check("R4 ba capture", a_out, 18'h33333);
    check("R8 b_out untouched", b_out, 18'h00077);

    // Output enables (R7)
    @(negedge clk); tb_drv_b = 0; ab_oe_n = 0; #1;
    check("R7 b_drive on", b_drive, 1);
    check("R7 a_drive off", a_drive, 0);
    @(negedge clk); tb_drv_a = 0; ba_oe_n = 0; #1;
    check("R7 a_drive on", a_drive, 1);
    @(negedge clk); ab_oe_n = 1; ba_oe_n = 1; #1;
    check("R7 both off", {a_drive, b_drive}, 0);
    tb_drv_a = 1; tb_drv_b = 1;

    // Reset mid-run (R9)
    @(negedge clk); ab_oe_n = 0; tb_drv_b = 0; rst_n = 0; #1;
    check("R9 b cleared", b_out, 0);
    check("R9 a cleared", a_out, 0);
    check("R9 drive follows oe", b_drive, 1);
    @(negedge clk); rst_n = 1; ab_oe_n = 1;
    @(negedge clk); #1;
    check("R9 held zero after reset", b_out, 0);
    check("R7 no contention", contention, 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule